// File: doc/BRIEF.md
# Nonvolatile SRAM Sequence Controller

This block is a synchronous model of a 2048 x 8 static RAM with a shadow nonvolatile array of the same size behind it. The bus side uses an active-low chip select, an active-low output enable and an active-low write strobe. It has an 11-bit address, a write data input and a registered read data output with its own valid flag. Plain reads and writes go to the SRAM. The nonvolatile transfers are controlled only through the stream of reads.

A detector follows the reads. If five reads hit 0x000, 0x555, 0x2AA, 0x7FF and 0x0F0 in that order, the sixth read decides what happens. A read of 0x70F copies the whole SRAM into the shadow array (store). A read of 0x70E copies the shadow array back into the SRAM (recall). Any write, or a read of an address that is not next in the sequence, abandons the sequence.

While a transfer runs, the bus is locked and `busy` is high. A recall also runs automatically after reset, so data saved by a store survives a reset. The length of each transfer is set by a parameter in clock cycles.

Top module: `nvsram_seq_ctrl`

## Requirements
- R1: A cycle with `ce_n`=0 and `we_n`=0 writes `din` to `addr`. A cycle with `ce_n`=0, `oe_n`=0 and `we_n`=1 is a read. After the next clock edge of that read, `dout_en`=1 and `dout` holds the byte at `addr`.
- R2: A read with `oe_n`=1 leaves `dout_en`=0 and `dout`=0x00, but it still counts as a step of the transfer sequence.
- R3: Reads of 0x000, 0x555, 0x2AA, 0x7FF, 0x0F0 and then 0x70F start a store. `busy` is high for exactly STORE_CYC cycles, starting at the edge that accepts the sixth read. The SRAM contents are unchanged afterwards.
- R4: The same five reads followed by a read of 0x70E start a recall. `busy` is high for exactly RECALL_CYC cycles. Afterwards every SRAM byte equals the value saved by the last store, and bytes written since that store are replaced.
- R5: A write anywhere inside the sequence aborts it, and the final read then starts no transfer (`busy` stays 0).
- R6: A read of an address that is not next in the sequence aborts it. Cycles with `ce_n`=1 leave the sequence position unchanged.
- R7: An aborting read of 0x000 counts as the first step of a new sequence.
- R8: While `busy` is high, writes do not change the SRAM, reads give `dout_en`=0, and reads do not advance the sequence. The sixth read of a sequence gives no output either.
- R9: During reset `busy`=1 and `dout_en`=0. After reset is released, `busy` stays high for exactly RESTORE_CYC cycles while a recall runs, so data saved by a store is readable after reset.
- R10: A recall does not alter the shadow array, so repeated recalls return the same saved data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not valid |
| dout_en | output | 1 | Read data valid |
| busy | output | 1 | Bus locked by a store, recall or restore |

## Verification
Read data and `dout_en` are due one edge after the read is presented. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge, so every result is compared right after the edge that registers it. `busy` rises at the same edge that accepts the sixth read. The bench counts `busy` samples from that edge until it drops and compares the count with the parameter. After reset the count starts at the first edge with reset low. The effects of a transfer on memory contents are checked by reads issued only after `busy` has fallen.

// File: rtl/nvs_pkg.sv
`timescale 1ns/1ps
package nvs_pkg;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int KEY_N  = 5;
    localparam int STEP_W = $clog2(KEY_N + 1);

    localparam logic [ADDR_W-1:0] KEY_STORE  = 11'h70F;
    localparam logic [ADDR_W-1:0] KEY_RECALL = 11'h70E;

    typedef enum logic {XFER_STORE, XFER_RECALL} xfer_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [ADDR_W-1:0] key_addr(input logic [STEP_W-1:0] step);
        case (step)
            3'd0:    return 11'h000;
            3'd1:    return 11'h555;
            3'd2:    return 11'h2AA;
            3'd3:    return 11'h7FF;
            3'd4:    return 11'h0F0;
            default: return 11'h000;
        endcase
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/nvs_seq_detect.sv
`timescale 1ns/1ps
module nvs_seq_detect
    import nvs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic     fire,
    output xfer_e    fire_kind
);
    logic [STEP_W-1:0] step;
    logic              at_last;
    logic              hit_store;
    logic              hit_recall;

    assign at_last    = (step == STEP_W'(KEY_N));
    assign hit_store  = (req.addr == KEY_STORE);
    assign hit_recall = (req.addr == KEY_RECALL);

    always_comb begin
        fire      = req.rd && at_last && (hit_store || hit_recall);
        fire_kind = hit_store ? XFER_STORE : XFER_RECALL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= '0;
        end else if (req.wr) begin
            step <= '0;
        end else if (req.rd) begin
            if (!at_last && req.addr == key_addr(step))
                step <= step + 1'b1;
            else if (req.addr == key_addr('0))
                step <= STEP_W'(1);
            else
                step <= '0;
        end
    end
endmodule

// File: rtl/nvs_xfer_ctrl.sv
`timescale 1ns/1ps
module nvs_xfer_ctrl
    import nvs_pkg::*;
#(
    parameter int STORE_CYC   = 20,
    parameter int RECALL_CYC  = 8,
    parameter int RESTORE_CYC = 12,
    parameter int CNT_W       = 5
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  fire,
    input  xfer_e fire_kind,
    output logic  busy,
    output logic  do_clear,
    output logic  do_copy,
    output xfer_e kind
);
    logic             active;
    logic             first;
    logic [CNT_W-1:0] cnt;

    assign busy     = active;
    assign do_clear = active && first;
    assign do_copy  = active && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b1;
            first  <= 1'b1;
            kind   <= XFER_RECALL;
            cnt    <= CNT_W'(RESTORE_CYC);
        end else if (active) begin
            first <= 1'b0;
            if (cnt == '0)
                active <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end else if (fire) begin
            active <= 1'b1;
            first  <= 1'b1;
            kind   <= fire_kind;
            cnt    <= (fire_kind == XFER_STORE) ? CNT_W'(STORE_CYC - 1)
                                                : CNT_W'(RECALL_CYC - 1);
        end
    end
endmodule

// File: rtl/nvs_array.sv
`timescale 1ns/1ps
module nvs_array
    import nvs_pkg::*;
(
    input  logic              clk,
    input  bus_req_t          req,
    input  logic              do_clear,
    input  logic              do_copy,
    input  xfer_e             kind,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] sram   [DEPTH];
    logic [DATA_W-1:0] shadow [DEPTH];

    always_ff @(posedge clk) begin
        if (kind == XFER_STORE && (do_copy || do_clear)) begin
            for (int i = 0; i < DEPTH; i++)
                shadow[i] <= do_copy ? sram[i] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (kind == XFER_RECALL && (do_copy || do_clear)) begin
            for (int i = 0; i < DEPTH; i++)
                sram[i] <= do_copy ? shadow[i] : '0;
        end else if (req.wr) begin
            sram[req.addr] <= req.wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (req.rd)
            rdata <= sram[req.addr];
    end
endmodule

// File: rtl/nvsram_seq_ctrl.sv
`timescale 1ns/1ps
module nvsram_seq_ctrl
    import nvs_pkg::*;
#(
    parameter int STORE_CYC   = 20,
    parameter int RECALL_CYC  = 8,
    parameter int RESTORE_CYC = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              busy
);
    localparam int CNT_W = $clog2(max3(STORE_CYC, RECALL_CYC, RESTORE_CYC) + 1);

    bus_req_t          req;
    logic              fire;
    xfer_e             fire_kind;
    xfer_e             kind;
    logic              do_clear;
    logic              do_copy;
    logic [DATA_W-1:0] rdata;

    always_comb begin
        req.rd    = !ce_n && we_n && !busy;
        req.wr    = !ce_n && !we_n && !busy;
        req.addr  = addr;
        req.wdata = din;
    end

    nvs_seq_detect u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .fire      (fire),
        .fire_kind (fire_kind)
    );

    nvs_xfer_ctrl #(
        .STORE_CYC   (STORE_CYC),
        .RECALL_CYC  (RECALL_CYC),
        .RESTORE_CYC (RESTORE_CYC),
        .CNT_W       (CNT_W)
    ) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .fire_kind (fire_kind),
        .busy      (busy),
        .do_clear  (do_clear),
        .do_copy   (do_copy),
        .kind      (kind)
    );

    nvs_array u_mem (
        .clk      (clk),
        .req      (req),
        .do_clear (do_clear),
        .do_copy  (do_copy),
        .kind     (kind),
        .rdata    (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)
            dout_en <= 1'b0;
        else
            dout_en <= req.rd && !oe_n && !fire;
    end

    assign dout = dout_en ? rdata : '0;
endmodule

// File: rtl/nvs_checker.sv
`timescale 1ns/1ps
module nvs_checker
    import nvs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              busy,
    input logic              dout_en,
    input logic [DATA_W-1:0] dout,
    input logic              fire,
    input xfer_e             fire_kind
);
    assert_read_origin_R1: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> $past(!ce_n && !oe_n && we_n));

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> dout == '0);

    assert_store_lock_R3: assert property (@(posedge clk) disable iff (rst)
        (fire && fire_kind == XFER_STORE) |=> busy);

    assert_recall_lock_R4: assert property (@(posedge clk) disable iff (rst)
        (fire && fire_kind == XFER_RECALL) |=> busy);

    assert_no_fire_busy_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !fire);

    assert_quiet_busy_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !dout_en);

    assert_restore_start_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> busy);
endmodule

bind nvsram_seq_ctrl nvs_checker u_nvs_checker (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .busy      (busy),
    .dout_en   (dout_en),
    .dout      (dout),
    .fire      (fire),
    .fire_kind (fire_kind)
);

// File: tb/test_nvsram_seq_ctrl.sv
`timescale 1ns/1ps
module test_nvsram_seq_ctrl;
    localparam int STORE_CYC   = 20;
    localparam int RECALL_CYC  = 8;
    localparam int RESTORE_CYC = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    logic        busy;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    nvsram_seq_ctrl #(
        .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC), .RESTORE_CYC(RESTORE_CYC)
    ) i_nvsram_seq_ctrl (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    typedef struct packed {
        logic        ce_n;
        logic        oe_n;
        logic        we_n;
        logic [10:0] a;
        logic [7:0]  d;
        logic        en;
        logic [7:0]  q;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{1'b0, 1'b1, 1'b0, 11'h123, 8'hA5, 1'b0, 8'h00},
        '{1'b0, 1'b1, 1'b0, 11'h7FF, 8'h3C, 1'b0, 8'h00},
        '{1'b0, 1'b1, 1'b0, 11'h055, 8'h11, 1'b0, 8'h00},
        '{1'b0, 1'b0, 1'b1, 11'h123, 8'h00, 1'b1, 8'hA5},
        '{1'b0, 1'b0, 1'b1, 11'h7FF, 8'h00, 1'b1, 8'h3C},
        '{1'b0, 1'b1, 1'b1, 11'h123, 8'h00, 1'b0, 8'h00},
        '{1'b1, 1'b0, 1'b1, 11'h123, 8'h00, 1'b0, 8'h00},
        '{1'b0, 1'b1, 1'b0, 11'h123, 8'h5A, 1'b0, 8'h00},
        '{1'b0, 1'b0, 1'b1, 11'h123, 8'h00, 1'b1, 8'h5A}
    };

    localparam logic [10:0] KEYS [5] = '{11'h000, 11'h555, 11'h2AA, 11'h7FF, 11'h0F0};

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic c, input logic o, input logic w,
                       input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; addr = a; din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(1'b1, 1'b1, 1'b1, 11'h000, 8'h00);
    endtask

    task automatic rd(input logic [10:0] a);
        cyc(1'b0, 1'b0, 1'b1, a, 8'h00);
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        cyc(1'b0, 1'b1, 1'b0, a, d);
    endtask

    task automatic run_seq(input logic [10:0] last, input logic oe);
        for (int k = 0; k < 5; k++) cyc(1'b0, oe, 1'b1, KEYS[k], 8'h00);
        cyc(1'b0, oe, 1'b1, last, 8'h00);
    endtask

    task automatic busy_run(inout int n);
        while (busy && n < 1000) begin
            n++;
            if (dout_en) chk("R8 output during busy", 1, 0);
            idle();
        end
    endtask

    task automatic read_chk(input string req, input logic [10:0] a, input logic [7:0] exp);
        rd(a);
        chk(req, {dout_en, dout}, {1'b1, exp});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 busy in reset", busy, 1);
        chk("R9 dout_en in reset", dout_en, 0);
        @(negedge clk);
        rst = 1'b0;
        n = 0;
        do begin
            @(posedge clk);
            #1;
            if (busy) n++;
        end while (busy && n < 1000);
        chk("R9 restore length", n, RESTORE_CYC);

        // R1 R2 vector table
        for (int i = 0; i < 9; i++) begin
            cyc(VEC[i].ce_n, VEC[i].oe_n, VEC[i].we_n, VEC[i].a, VEC[i].d);
            chk($sformatf("R1/R2 vector %0d", i), {dout_en, dout}, {VEC[i].en, VEC[i].q});
        end

        // R3 store, with bus activity during busy (R8)
        run_seq(11'h70F, 1'b0);
        chk("R8 sixth read output", dout_en, 0);
        chk("R3 busy after store key", busy, 1);
        n = 0;
        for (int k = 0; k < 3; k++) begin
            n++;
            if (k == 0) wr(11'h055, 8'h99);
            else rd(11'h055);
            chk("R8 read during busy", dout_en, 0);
        end
        busy_run(n);
        chk("R3 store length", n, STORE_CYC);
        read_chk("R8 write ignored while busy", 11'h055, 8'h11);

        // R4 recall replaces newer data
        wr(11'h055, 8'h77);
        read_chk("R1 overwrite", 11'h055, 8'h77);
        run_seq(11'h70E, 1'b0);
        n = 0;
        busy_run(n);
        chk("R4 recall length", n, RECALL_CYC);
        read_chk("R4 recalled 055", 11'h055, 8'h11);
        read_chk("R4 recalled 123", 11'h123, 8'h5A);
        read_chk("R4 recalled 7FF", 11'h7FF, 8'h3C);

        // R10 repeated recall
        wr(11'h055, 8'h22);
        run_seq(11'h70E, 1'b0);
        n = 0;
        busy_run(n);
        read_chk("R10 second recall", 11'h055, 8'h11);

        // R5 write aborts
        rd(11'h000); rd(11'h555); wr(11'h300, 8'h01);
        rd(11'h2AA); rd(11'h7FF); rd(11'h0F0); rd(11'h70F);
        chk("R5 write aborts", busy, 0);
        idle();
        chk("R5 still idle", busy, 0);

        // R6 wrong read aborts
        rd(11'h000); rd(11'h555); rd(11'h2AA); rd(11'h100);
        rd(11'h7FF); rd(11'h0F0); rd(11'h70E);
        chk("R6 wrong address aborts", busy, 0);

        // R6 idle cycles keep position
        wr(11'h055, 8'h33);
        for (int k = 0; k < 5; k++) begin
            rd(KEYS[k]);
            idle();
            idle();
        end
        rd(11'h70E);
        chk("R6 idles keep sequence", busy, 1);
        n = 0;
        busy_run(n);
        read_chk("R6 recall after idles", 11'h055, 8'h11);

        // R7 abort at 0x000 restarts at step two
        wr(11'h055, 8'h44);
        rd(11'h000); rd(11'h555); rd(11'h000);
        rd(11'h555); rd(11'h2AA); rd(11'h7FF); rd(11'h0F0); rd(11'h70E);
        chk("R7 restart via 000", busy, 1);
        n = 0;
        busy_run(n);
        read_chk("R7 recall data", 11'h055, 8'h11);

        // R8 reads during busy do not advance the sequence
        run_seq(11'h70E, 1'b0);
        for (int k = 0; k < 5; k++) rd(KEYS[k]);
        n = 0;
        busy_run(n);
        rd(11'h70F);
        chk("R8 busy reads not counted", busy, 0);

        // R2 sequence with oe_n high
        wr(11'h055, 8'h66);
        run_seq(11'h70E, 1'b1);
        chk("R2 oe high still counts", busy, 1);
        n = 0;
        busy_run(n);
        read_chk("R2 recall data", 11'h055, 8'h11);

        // R9 data survives reset
        wr(11'h055, 8'h55);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        n = 0;
        do begin
            @(posedge clk);
            #1;
            if (busy) n++;
        end while (busy && n < 1000);
        chk("R9 restore length after pulse", n, RESTORE_CYC);
        read_chk("R9 data after reset", 11'h055, 8'h11);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule